// File: doc/BRIEF.md
# Stack push sequencer

This block carries out a push of several registers onto a downward-growing stack. A request names its register set in one of four ways: a raw 16-bit register mask, a 16-bit short push encoding, a 32-bit list push encoding, or a 32-bit single-register push encoding. From the selected set the block computes the lowered stack pointer. It then issues one 32-bit word store per selected register over a valid/ready memory write channel. Register contents are fetched through a combinational read port into an external register file.

When the last store has been accepted, the block pulses `done_o`. In that same cycle it presents the new stack pointer for write-back. The caller supplies the current SP and the value to store for the program counter slot. The block touches no condition flags and reports no faults.

Top module: `push_engine`

## Requirements
- R1: With `src_i` = 1 (short form), the request is valid only when `instr_i[15:9]` = 1011010. Bits [7:0] then select R0 to R7, and bit 8 adds R14. Any other pattern selects no registers.
- R2: `src_i` = 0 takes `instr_i[15:0]` as the mask directly. `src_i` = 2 takes `instr_i[15:0]` as the mask when `instr_i[31:16]` = 16'hE92D. `src_i` = 3 pushes the single register numbered `instr_i[15:12]` when `instr_i[31:16]` = 16'hF84D and `instr_i[11:0]` = 12'hD04. A mismatched tag selects no registers.
- R3: With N registers selected, the first store goes to SP − 4·N. Stores follow ascending register number, each at the previous address + 4.
- R4: `done_o` and `sp_wr_en_o` are high together for exactly one cycle, the cycle after the last store is accepted. `sp_wr_data_o` is then SP − 4·N.
- R5: For an ordinary register, `rf_rd_idx_o` carries its number while its store is offered, and the store data equals `rf_rd_data_i`.
- R6: A store for register 13 writes the original SP when 13 is the lowest selected register, and writes zero otherwise. The store is still performed in both cases.
- R7: Register 15 is stored last, at the highest address, with data `pc_val_i`.
- R8: At most one store is accepted per cycle, on `mem_valid_o && mem_ready_i`. While valid is high and ready is low, address and data hold steady.
- R9: An empty selection performs no store and does not assert `sp_wr_en_o`. `done_o` rises in the cycle after the start is taken.
- R10: A start that arrives while the block is busy is ignored.
- R11: After reset the block is idle. `busy_o` rises in the cycle after a start is taken. For a non-empty selection, the first store is offered in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, taken when idle |
| src_i | input | 2 | Request format: 0 mask, 1 short, 2 wide list, 3 wide single |
| instr_i | input | 32 | Mask or encoded request |
| sp_i | input | 32 | Current stack pointer |
| pc_val_i | input | 32 | Value stored for register 15 |
| rf_rd_idx_o | output | 4 | Register file read index |
| rf_rd_data_i | input | 32 | Register file read data |
| mem_valid_o | output | 1 | Store offered |
| mem_ready_i | input | 1 | Store accepted when high with valid |
| mem_addr_o | output | 32 | Store byte address |
| mem_data_o | output | 32 | Store word |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sp_wr_en_o | output | 1 | New SP write-back strobe |
| sp_wr_data_o | output | 32 | New SP value |

## Verification
The first store is due one cycle after the start edge. For an empty selection, `done_o` is due at that same point instead. Every later store follows the previous accepted one, however many stall cycles the ready line inserts. The SP write-back and `done_o` come exactly one cycle after the final acceptance. The bench samples every output at the falling edge, with ready changed shortly after the rising edge. Each accepted store is compared against the next queued item. The completion checks are tied to the cycle after the queue drains rather than to a fixed count.

// File: rtl/push_pkg.sv
package push_pkg;

  typedef enum logic [1:0] {
    SRC_MASK      = 2'd0,
    SRC_SHORT     = 2'd1,
    SRC_WIDE_LIST = 2'd2,
    SRC_WIDE_ONE  = 2'd3
  } push_src_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STORE  = 2'd1,
    ST_FINISH = 2'd2
  } push_state_e;

  localparam int unsigned REG_SP = 13;
  localparam int unsigned REG_LR = 14;
  localparam int unsigned REG_PC = 15;

endpackage

// File: rtl/push_decode.sv
module push_decode #(
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned MASK_W  = 16
) (
  input  push_pkg::push_src_e  src_i,
  input  logic [INSTR_W-1:0]   instr_i,
  output logic [MASK_W-1:0]    mask_o
);
  import push_pkg::*;

  localparam logic [6:0]  SHORT_TAG     = 7'b1011010;
  localparam logic [15:0] WIDE_LIST_TAG = 16'hE92D;
  localparam logic [15:0] WIDE_ONE_TAG  = 16'hF84D;
  localparam logic [11:0] WIDE_ONE_TAIL = 12'hD04;

  always_comb begin
    mask_o = '0;
    case (src_i)
      SRC_MASK: mask_o = instr_i[MASK_W-1:0];
      SRC_SHORT: begin
        if (instr_i[15:9] == SHORT_TAG) begin
          mask_o[7:0]    = instr_i[7:0];
          mask_o[REG_LR] = instr_i[8];
        end
      end
      SRC_WIDE_LIST: begin
        if (instr_i[31:16] == WIDE_LIST_TAG) mask_o = instr_i[MASK_W-1:0];
      end
      SRC_WIDE_ONE: begin
        if (instr_i[31:16] == WIDE_ONE_TAG && instr_i[11:0] == WIDE_ONE_TAIL)
          mask_o[instr_i[15:12]] = 1'b1;
      end
      default: mask_o = '0;
    endcase
  end

endmodule

// File: rtl/push_pick.sv
module push_pick #(
  parameter int unsigned W     = 16,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     mask_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |mask_i;

endmodule

// File: rtl/push_count.sv
module push_count #(
  parameter int unsigned W     = 16,
  parameter int unsigned CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     mask_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) begin
      cnt_o = cnt_o + CNT_W'(mask_i[i]);
    end
  end

endmodule

// File: rtl/push_store_fsm.sv
module push_store_fsm #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned MASK_W     = 16,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [MASK_W-1:0]         mask_i,
  input  logic [ADDR_W-1:0]         sp_i,
  input  logic [DATA_W-1:0]         pc_val_i,
  output logic [$clog2(MASK_W)-1:0] rf_rd_idx_o,
  input  logic [DATA_W-1:0]         rf_rd_data_i,
  output logic                      mem_valid_o,
  input  logic                      mem_ready_i,
  output logic [ADDR_W-1:0]         mem_addr_o,
  output logic [DATA_W-1:0]         mem_data_o,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      sp_wr_en_o,
  output logic [ADDR_W-1:0]         sp_wr_data_o
);
  import push_pkg::*;

  localparam int unsigned IDX_W   = $clog2(MASK_W);
  localparam int unsigned CNT_W   = $clog2(MASK_W + 1);
  localparam int unsigned SHIFT   = $clog2(WORD_BYTES);
  localparam logic [IDX_W-1:0] IDX_SP = IDX_W'(REG_SP);
  localparam logic [IDX_W-1:0] IDX_PC = IDX_W'(REG_PC);

  push_state_e       state_q, state_d;
  logic [MASK_W-1:0] left_q, left_d;
  logic [IDX_W-1:0]  low_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] base_q, sp_orig_q;
  logic              nonempty_q;

  logic [CNT_W-1:0]  cnt_start;
  logic [IDX_W-1:0]  low_start, cur_idx;
  logic              any_start, any_left;
  logic              take, fire;
  logic [ADDR_W-1:0] base_start;

  push_count #(.W(MASK_W), .CNT_W(CNT_W)) u_count (
    .mask_i (mask_i),
    .cnt_o  (cnt_start)
  );

  push_pick #(.W(MASK_W), .IDX_W(IDX_W)) u_pick_start (
    .mask_i (mask_i),
    .idx_o  (low_start),
    .any_o  (any_start)
  );

  push_pick #(.W(MASK_W), .IDX_W(IDX_W)) u_pick_left (
    .mask_i (left_q),
    .idx_o  (cur_idx),
    .any_o  (any_left)
  );

  assign take       = start_i && (state_q == ST_IDLE);
  assign fire       = (state_q == ST_STORE) && mem_ready_i;
  assign base_start = sp_i - (ADDR_W'(cnt_start) << SHIFT);

  // next-state logic
  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    addr_d  = addr_q;
    case (state_q)
      ST_IDLE: begin
        if (take) begin
          left_d  = mask_i;
          addr_d  = base_start;
          state_d = any_start ? ST_STORE : ST_FINISH;
        end
      end
      ST_STORE: begin
        if (fire) begin
          left_d = left_q & ~(MASK_W'(1) << cur_idx);
          addr_d = addr_q + ADDR_W'(WORD_BYTES);
          if (left_d == '0) state_d = ST_FINISH;
        end
      end
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      addr_q  <= addr_d;
    end
  end

  // request context, loaded only when a start is taken
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q      <= '0;
      base_q     <= '0;
      sp_orig_q  <= '0;
      nonempty_q <= 1'b0;
    end else if (take) begin
      low_q      <= low_start;
      base_q     <= base_start;
      sp_orig_q  <= sp_i;
      nonempty_q <= any_start;
    end
  end

  // store data selection
  always_comb begin
    if (cur_idx == IDX_PC)      mem_data_o = pc_val_i;
    else if (cur_idx == IDX_SP) mem_data_o = (low_q == IDX_SP) ? sp_orig_q : '0;
    else                        mem_data_o = rf_rd_data_i;
  end

  assign rf_rd_idx_o  = cur_idx;
  assign mem_valid_o  = (state_q == ST_STORE);
  assign mem_addr_o   = addr_q;
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = (state_q == ST_FINISH);
  assign sp_wr_en_o   = done_o && nonempty_q;
  assign sp_wr_data_o = base_q;

  // assertions
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(rf_rd_idx_o));

  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && mem_ready_i |=> !mem_valid_o || (mem_addr_o == $past(mem_addr_o) + ADDR_W'(WORD_BYTES)));

  assert_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && mem_ready_i |=> !mem_valid_o || (rf_rd_idx_o > $past(rf_rd_idx_o)));

  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_sp_with_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_wr_en_o |-> done_o && !mem_valid_o);

  assert_end_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && nonempty_q |-> addr_q == sp_orig_q);

  assert_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);

  assert_ignore_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> $stable(sp_wr_data_o));

endmodule

// File: rtl/push_engine.sv
module push_engine #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned INSTR_W    = 32,
  parameter int unsigned MASK_W     = 16,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [1:0]                src_i,
  input  logic [INSTR_W-1:0]        instr_i,
  input  logic [ADDR_W-1:0]         sp_i,
  input  logic [DATA_W-1:0]         pc_val_i,
  output logic [$clog2(MASK_W)-1:0] rf_rd_idx_o,
  input  logic [DATA_W-1:0]         rf_rd_data_i,
  output logic                      mem_valid_o,
  input  logic                      mem_ready_i,
  output logic [ADDR_W-1:0]         mem_addr_o,
  output logic [DATA_W-1:0]         mem_data_o,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      sp_wr_en_o,
  output logic [ADDR_W-1:0]         sp_wr_data_o
);
  import push_pkg::*;

  logic [1:0]        rst_pipe_q;
  logic              rst_n_int;
  logic [MASK_W-1:0] mask;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  push_decode #(.INSTR_W(INSTR_W), .MASK_W(MASK_W)) u_decode (
    .src_i   (push_src_e'(src_i)),
    .instr_i (instr_i),
    .mask_o  (mask)
  );

  push_store_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_W(MASK_W), .WORD_BYTES(WORD_BYTES)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_int),
    .start_i      (start_i),
    .mask_i       (mask),
    .sp_i         (sp_i),
    .pc_val_i     (pc_val_i),
    .rf_rd_idx_o  (rf_rd_idx_o),
    .rf_rd_data_i (rf_rd_data_i),
    .mem_valid_o  (mem_valid_o),
    .mem_ready_i  (mem_ready_i),
    .mem_addr_o   (mem_addr_o),
    .mem_data_o   (mem_data_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .sp_wr_en_o   (sp_wr_en_o),
    .sp_wr_data_o (sp_wr_data_o)
  );

endmodule

// File: tb/push_engine_tb_top.sv
module push_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  src = '0;
  logic [31:0] instr = '0;
  logic [31:0] sp_in = '0;
  logic [31:0] pc_val = 32'h0800_1234;
  logic [3:0]  rd_idx;
  logic [31:0] rd_data;
  logic        mem_valid, mem_ready, busy, done, sp_we;
  logic [31:0] mem_addr, mem_data, sp_wd;

  int unsigned n_cmp = 0, n_bad = 0, cycles = 0;
  bit          ready_rnd = 1'b0;
  logic [7:0]  lfsr = 8'hA7;

  logic [31:0] exp_addr_q[$];
  logic [31:0] exp_data_q[$];
  string       exp_req_q[$];
  logic [31:0] exp_sp;
  bit          hold_pend = 1'b0, last_pend = 1'b0;
  logic [31:0] hold_addr, hold_data;

  always #2 clk = ~clk;

  function automatic logic [31:0] rf_val(input logic [3:0] i);
    return 32'hC0DE_0000 + 32'h0000_0101 * {28'd0, i};
  endfunction

  assign rd_data = rf_val(rd_idx);

  push_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .src_i(src), .instr_i(instr),
    .sp_i(sp_in), .pc_val_i(pc_val), .rf_rd_idx_o(rd_idx), .rf_rd_data_i(rd_data),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_addr_o(mem_addr),
    .mem_data_o(mem_data), .busy_o(busy), .done_o(done), .sp_wr_en_o(sp_we),
    .sp_wr_data_o(sp_wd)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ready changes shortly after the rising edge
  always @(posedge clk) begin
    #1;
    if (ready_rnd) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_ready = lfsr[0];
    end else begin
      mem_ready = 1'b1;
    end
  end

  // expected mask, from the request rules
  function automatic logic [15:0] exp_mask(input logic [1:0] k, input logic [31:0] w);
    logic [15:0] m = '0;
    case (k)
      2'd0: m = w[15:0];
      2'd1: if (w[15:9] == 7'b1011010) m = {1'b0, w[8], 6'd0, w[7:0]};
      2'd2: if (w[31:16] == 16'hE92D) m = w[15:0];
      default: if (w[31:16] == 16'hF84D && w[11:0] == 12'hD04) m[w[15:12]] = 1'b1;
    endcase
    return m;
  endfunction

  // monitor: scoreboard compare of every accepted store
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        chk(mem_valid && mem_addr == hold_addr, "R8 held address", mem_addr, hold_addr);
        chk(mem_data == hold_data, "R8 held data", mem_data, hold_data);
      end
      hold_pend = mem_valid && !mem_ready;
      hold_addr = mem_addr;
      hold_data = mem_data;
      if (last_pend) begin
        chk(done && sp_we, "R4 done with sp write after last store", {30'd0, done, sp_we}, 32'd3);
        chk(sp_wd == exp_sp, "R4 new SP", sp_wd, exp_sp);
        last_pend = 1'b0;
      end
      if (mem_valid && mem_ready) begin
        if (exp_addr_q.size() == 0) begin
          chk(1'b0, "R3 unexpected store", mem_addr, 32'd0);
        end else begin
          logic [31:0] ea, ed;
          string r;
          ea = exp_addr_q.pop_front();
          ed = exp_data_q.pop_front();
          r  = exp_req_q.pop_front();
          chk(mem_addr == ea, "R3 store address", mem_addr, ea);
          chk(mem_data == ed, r, mem_data, ed);
          if (exp_addr_q.size() == 0) last_pend = 1'b1;
        end
      end
    end
  end

  // driver: queue the expected stores, then issue the request
  task automatic run_op(input logic [1:0] k, input logic [31:0] w, input logic [31:0] sp,
                        input bit rnd, input bit poke);
    logic [15:0] m;
    int n = 0, low = -1, j = 0;
    logic [31:0] base;
    m = exp_mask(k, w);
    for (int i = 0; i < 16; i++) if (m[i]) begin n++; if (low < 0) low = i; end
    base = sp - 32'(4 * n);
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        exp_addr_q.push_back(base + 32'(4 * j));
        if (i == 15) begin
          exp_data_q.push_back(pc_val); exp_req_q.push_back("R7 PC store data");
        end else if (i == 13) begin
          exp_data_q.push_back(low == 13 ? sp : 32'd0); exp_req_q.push_back("R6 SP store data");
        end else begin
          exp_data_q.push_back(rf_val(4'(i))); exp_req_q.push_back("R5 register data");
        end
        j++;
      end
    end
    exp_sp = base;
    @(negedge clk);
    ready_rnd = rnd;
    start = 1'b1; src = k; instr = w; sp_in = sp;
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      chk(done && !mem_valid && !sp_we, "R9 empty completes at once", {29'd0, done, mem_valid, sp_we}, 32'd4);
    end else begin
      chk(busy && mem_valid, "R11 first store offered", {30'd0, busy, mem_valid}, 32'd3);
      chk(mem_addr == base, "R3 first address", mem_addr, base);
    end
    if (poke) begin
      start = 1'b1; src = 2'd0; instr = 32'h0000_00FF; sp_in = sp;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(exp_addr_q.size() == 0, "R4 all stores done at completion", exp_addr_q.size(), 32'd0);
    @(negedge clk);
    chk(!busy && !mem_valid, "R10 idle after completion", {30'd0, busy, mem_valid}, 32'd0);
  endtask

  initial begin : watchdog
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    chk(1'b0, "watchdog expired", cycles, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stimulus
    mem_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_valid && !done && !sp_we, "R11 idle in reset",
        {28'd0, busy, mem_valid, done, sp_we}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !mem_valid && !done, "R11 idle after reset", {29'd0, busy, mem_valid, done}, 32'd0);

    run_op(2'd0, 32'h0000_0001, 32'h2000_0100, 1'b0, 1'b0);  // R2 direct, R3 single word
    run_op(2'd1, 32'h0000_B583, 32'h2000_0200, 1'b0, 1'b0);  // R1 short with LR
    run_op(2'd1, 32'h0000_B683, 32'h2000_0300, 1'b0, 1'b0);  // R1 bad tag -> empty
    run_op(2'd2, 32'hE92D_A00C, 32'h2000_0400, 1'b1, 1'b0);  // R6 SP not lowest, R7 PC
    run_op(2'd2, 32'hE92D_6000, 32'h2000_0500, 1'b0, 1'b0);  // R6 SP lowest
    run_op(2'd3, 32'hF84D_5D04, 32'h2000_0600, 1'b1, 1'b0);  // R2 single register
    run_op(2'd2, 32'hE82D_00FF, 32'h2000_0700, 1'b0, 1'b0);  // R2 wrong tag -> empty
    run_op(2'd0, 32'h0000_0000, 32'h2000_0800, 1'b0, 1'b0);  // R9 empty mask
    run_op(2'd0, 32'h0000_FFFF, 32'h2000_0900, 1'b1, 1'b1);  // R8 stalls, R10 start while busy
    run_op(2'd1, 32'h0000_B5FF, 32'h2000_0A00, 1'b1, 1'b1);  // R1 full short list with stalls

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule